// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs the handshake for one 8-bit parallel port that exchanges bytes with a peripheral under strobe control. A direction input picks between receiving and sending. When receiving, the peripheral presents a byte and pulses an active-low strobe. On the strobe's return to high the byte is held in a latch, a buffer-full flag goes high and, when enabled, an interrupt request goes high. A CPU read of the data port empties the buffer and drops the request. When sending, a CPU write loads the output latch and pulls an active-low buffer-full line low. The peripheral takes the byte and pulses an active-low acknowledge. On the acknowledge's return to high the line goes back high and, when enabled, the interrupt request goes high. The next CPU write drops it.

The handshake lines sit at fixed bit positions of an 8-bit side port. The positions depend on which of two port slots the instance fills (parameter `PORT_B`) and on the direction. The interrupt enable is not a separate register. It is written through the side port's single-bit set/clear command aimed at the strobe/acknowledge position, and it reads back in that position of the side-port status word. Side-port bits that the handshake does not own keep working as plain I/O. The set/clear command drives them as outputs, and their status bits show the input pins. The strobe and acknowledge pass through a two-flop synchronizer and a rising-edge detector before they are used.

Top module: `hs_port`

## Requirements
- R1: After reset the buffer is empty, the interrupt request and enable are 0, both data latches are 0, the plain side-port outputs are 0 and the direction is receive. The buffer-full bit therefore reads 0 and the interrupt bit reads 0.
- R2: In receive mode with the buffer empty, data on `per_data_in` is sampled while the synchronized strobe is low. The strobe's return to high freezes the latch and sets buffer-full (side-port bit = 1) on the third rising clock edge after the pin goes high, not before.
- R3: A strobe that arrives while the receive buffer is full changes neither the latch nor the flags.
- R4: A `cpu_rd` pulse in receive mode clears buffer-full and the interrupt request.
- R5: A `cpu_wr` pulse in send mode loads `cpu_wdata` onto `per_data_out`, drives the active-low buffer-full bit to 0 and clears the interrupt request.
- R6: In send mode, an acknowledge whose synchronized level returns high while the active-low buffer-full bit is 0 sets that bit to 1. An acknowledge while the bit is already 1 has no effect.
- R7: Completing a transfer (R2 or R6) raises `irq` only if the enable is 1. Clearing the enable drops `irq`, so `irq` is never 1 while the enable is 0.
- R8: `cpu_wr` in receive mode and `cpu_rd` in send mode change no flag.
- R9: Bit positions, as (strobe-or-ack, buffer-full, interrupt). With `PORT_B`=0 they are (4,5,3) for receive and (6,7,3) for send. With `PORT_B`=1 they are (2,1,0) for both directions. `pc_pin_out` carries the buffer-full and interrupt values at their positions and 0 at the strobe/ack position.
- R10: In `pc_status`, the strobe/ack position shows the enable, the buffer-full and interrupt positions show their line values, and every other bit shows `pc_pin_in`.
- R11: A set/clear command (`bsr_valid`, `bsr_bit` = bit index 0..7, `bsr_val` = new value) writes the enable when aimed at the strobe/ack position. It is ignored at the buffer-full and interrupt positions. At any other bit it writes the plain output driven on `pc_pin_out`.
- R12: A change of `dir_out` takes effect one clock later. It empties the buffer, clears the interrupt request and clears the enable.
- R13: `cpu_rdata` returns the receive latch in receive mode and the send latch in send mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_out | input | 1 | 0 = receive, 1 = send |
| cpu_rd | input | 1 | One-cycle CPU read of the data port |
| cpu_wr | input | 1 | One-cycle CPU write of the data port |
| cpu_wdata | input | W | CPU write data |
| cpu_rdata | output | W | Data port read value |
| bsr_valid | input | 1 | Side-port bit set/clear command strobe |
| bsr_bit | input | 3 | Side-port bit index for the command |
| bsr_val | input | 1 | Value to write to the selected bit |
| pc_status | output | 8 | Side-port status word seen by the CPU |
| per_data_in | input | W | Peripheral data into the port |
| per_data_out | output | W | Latched data out to the peripheral |
| pc_pin_in | input | 8 | Side-port input pins (strobe/ack and plain inputs) |
| pc_pin_out | output | 8 | Side-port output values (handshake lines and plain outputs) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take it that a strobe or acknowledge pulse is held long enough for the synchronizer to see both its low and its high level. They also take it that the peripheral keeps its data steady while the strobe is low, and that a direction change, a CPU access and a handshake edge never fall in the same clock. The stimulus keeps to this: every operation is issued alone and followed by idle cycles, pulses stay low for four clocks, and the data bus changes only between operations. The strobe/ack pin positions are held high whenever no pulse is in progress, so a direction change never shows a false edge.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

    localparam int PC_W   = 8;
    localparam int PC_IDX = $clog2(PC_W);

    typedef logic [PC_IDX-1:0] pc_idx_t;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } hs_dir_e;

    // Side-port positions used by the handshake for one slot/direction
    typedef struct packed {
        pc_idx_t hs;   // strobe or acknowledge input, enable read-back
        pc_idx_t bf;   // buffer-full line
        pc_idx_t irq;  // interrupt request line
    } pc_map_t;

    // full: buffer holds data not yet consumed by the other side
    typedef struct packed {
        logic full;
        logic intr;
        logic inte;
    } hs_flags_t;

    function automatic pc_map_t pc_map(input logic port_b, input hs_dir_e d);
        pc_map_t m;
        if (port_b)
            m = '{hs: pc_idx_t'(2), bf: pc_idx_t'(1), irq: pc_idx_t'(0)};
        else if (d == DIR_IN)
            m = '{hs: pc_idx_t'(4), bf: pc_idx_t'(5), irq: pc_idx_t'(3)};
        else
            m = '{hs: pc_idx_t'(6), bf: pc_idx_t'(7), irq: pc_idx_t'(3)};
        return m;
    endfunction

    function automatic logic pc_owned(input pc_map_t m, input pc_idx_t b);
        return (b == m.hs) || (b == m.bf) || (b == m.irq);
    endfunction

    // Buffer-full pin: active high when receiving, active low when sending
    function automatic logic bf_line(input hs_dir_e d, input logic full);
        return (d == DIR_OUT) ? ~full : full;
    endfunction

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] sr;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= RST_VAL;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= {STAGES{RST_VAL}};
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= RST_VAL;
        else     last <= level;
    end

    assign level = sr[STAGES-1];
    assign rise  = level & ~last;
endmodule

// File: rtl/hs_core.sv
module hs_core
    import hs_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  hs_dir_e       dir,
    input  logic          dir_chg,
    input  logic          hs_level,
    input  logic          hs_rise,
    input  logic [W-1:0]  pin_data,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [W-1:0]  cpu_wdata,
    input  logic          inte_wr,
    input  logic          inte_val,
    output hs_flags_t     flags,
    output logic [W-1:0]  in_lat,
    output logic [W-1:0]  out_lat
);
    hs_flags_t nxt;
    logic      ev_done;
    logic      cap_en;
    logic      load_en;

    always_comb begin
        nxt     = flags;
        ev_done = 1'b0;
        if (inte_wr) nxt.inte = inte_val;
        if (dir_chg) begin
            nxt = '0;
        end else if (dir == DIR_IN) begin
            if (hs_rise && !flags.full) begin
                nxt.full = 1'b1;
                ev_done  = 1'b1;
            end else if (cpu_rd) begin
                nxt.full = 1'b0;
                nxt.intr = 1'b0;
            end
        end else begin
            if (cpu_wr) begin
                nxt.full = 1'b1;
                nxt.intr = 1'b0;
            end else if (hs_rise && flags.full) begin
                nxt.full = 1'b0;
                ev_done  = 1'b1;
            end
        end
        if (ev_done) nxt.intr = 1'b1;
        // request survives only under the enable as it will stand after this edge
        nxt.intr = nxt.intr & nxt.inte;
    end

    assign cap_en  = !dir_chg && (dir == DIR_IN) && !hs_level && !flags.full;
    assign load_en = !dir_chg && (dir == DIR_OUT) && cpu_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            in_lat  <= '0;
            out_lat <= '0;
        end else begin
            flags <= nxt;
            if (cap_en)  in_lat  <= pin_data;
            if (load_en) out_lat <= cpu_wdata;
        end
    end
endmodule

// File: rtl/hs_portc.sv
module hs_portc
    import hs_port_pkg::*;
#(
    parameter logic PORT_B = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  hs_dir_e          dir,
    input  hs_flags_t        flags,
    input  logic             bsr_valid,
    input  pc_idx_t          bsr_bit,
    input  logic             bsr_val,
    input  logic [PC_W-1:0]  pc_pin_in,
    output logic             hs_pin,
    output logic             inte_wr,
    output logic             inte_val,
    output logic [PC_W-1:0]  pc_status,
    output logic [PC_W-1:0]  pc_pin_out
);
    pc_map_t         map;
    logic            bf_pin;
    logic [PC_W-1:0] plain_q;

    assign map      = pc_map(PORT_B, dir);
    assign bf_pin   = bf_line(dir, flags.full);
    assign hs_pin   = pc_pin_in[map.hs];
    assign inte_wr  = bsr_valid && (bsr_bit == map.hs);
    assign inte_val = bsr_val;

    for (genvar b = 0; b < PC_W; b++) begin : g_bit
        localparam pc_idx_t IDX = pc_idx_t'(b);

        always_ff @(posedge clk) begin
            if (rst)
                plain_q[b] <= 1'b0;
            else if (bsr_valid && (bsr_bit == IDX) && !pc_owned(map, IDX))
                plain_q[b] <= bsr_val;
        end

        always_comb begin
            if (IDX == map.hs) begin
                pc_status[b]  = flags.inte;
                pc_pin_out[b] = 1'b0;
            end else if (IDX == map.bf) begin
                pc_status[b]  = bf_pin;
                pc_pin_out[b] = bf_pin;
            end else if (IDX == map.irq) begin
                pc_status[b]  = flags.intr;
                pc_pin_out[b] = flags.intr;
            end else begin
                pc_status[b]  = pc_pin_in[b];
                pc_pin_out[b] = plain_q[b];
            end
        end
    end
endmodule

// File: rtl/hs_port.sv
module hs_port
    import hs_port_pkg::*;
#(
    parameter int   W           = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic PORT_B      = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_out,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [W-1:0]  cpu_wdata,
    output logic [W-1:0]  cpu_rdata,
    input  logic          bsr_valid,
    input  logic [2:0]    bsr_bit,
    input  logic          bsr_val,
    output logic [7:0]    pc_status,
    input  logic [W-1:0]  per_data_in,
    output logic [W-1:0]  per_data_out,
    input  logic [7:0]    pc_pin_in,
    output logic [7:0]    pc_pin_out,
    output logic          irq
);
    hs_dir_e   dir_q;
    logic      dir_chg;
    hs_flags_t flags;
    logic      hs_pin;
    logic      hs_level;
    logic      hs_rise;
    logic      inte_wr;
    logic      inte_val;
    logic [W-1:0] in_lat;
    logic [W-1:0] out_lat;

    always_ff @(posedge clk) begin
        if (rst) dir_q <= DIR_IN;
        else     dir_q <= hs_dir_e'(dir_out);
    end
    assign dir_chg = (hs_dir_e'(dir_out) != dir_q);

    hs_portc #(.PORT_B(PORT_B)) u_portc (
        .clk        (clk),
        .rst        (rst),
        .dir        (dir_q),
        .flags      (flags),
        .bsr_valid  (bsr_valid),
        .bsr_bit    (pc_idx_t'(bsr_bit)),
        .bsr_val    (bsr_val),
        .pc_pin_in  (pc_pin_in),
        .hs_pin     (hs_pin),
        .inte_wr    (inte_wr),
        .inte_val   (inte_val),
        .pc_status  (pc_status),
        .pc_pin_out (pc_pin_out)
    );

    hs_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d     (hs_pin),
        .level (hs_level),
        .rise  (hs_rise)
    );

    hs_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .dir       (dir_q),
        .dir_chg   (dir_chg),
        .hs_level  (hs_level),
        .hs_rise   (hs_rise),
        .pin_data  (per_data_in),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .inte_wr   (inte_wr),
        .inte_val  (inte_val),
        .flags     (flags),
        .in_lat    (in_lat),
        .out_lat   (out_lat)
    );

    assign cpu_rdata    = (dir_q == DIR_OUT) ? out_lat : in_lat;
    assign per_data_out = out_lat;
    assign irq          = flags.intr;
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk
    import hs_port_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input hs_dir_e      dir_q,
    input logic         dir_chg,
    input logic         cpu_rd,
    input logic         cpu_wr,
    input logic         hs_rise,
    input hs_flags_t    flags,
    input logic [W-1:0] in_lat
);
    // R7: request never stands without the enable
    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        flags.intr |-> flags.inte);

    // R4: a receive-side read empties the buffer
    a_r4_read_empties: assert property (@(posedge clk) disable iff (rst)
        (!dir_chg && dir_q == DIR_IN && cpu_rd && !hs_rise) |=> !flags.full);

    // R5: a send-side write fills the buffer and drops the request
    a_r5_write_fills: assert property (@(posedge clk) disable iff (rst)
        (!dir_chg && dir_q == DIR_OUT && cpu_wr) |=> (flags.full && !flags.intr));

    // R2: a full receive buffer holds its byte
    a_r2_hold_while_full: assert property (@(posedge clk) disable iff (rst)
        (dir_q == DIR_IN && flags.full && $past(flags.full)) |-> $stable(in_lat));

    // R3: a strobe into a full buffer leaves it full
    a_r3_no_refill: assert property (@(posedge clk) disable iff (rst)
        (!dir_chg && dir_q == DIR_IN && flags.full && hs_rise && !cpu_rd) |=> flags.full);

    // R12: a direction change clears flags and enable
    a_r12_dir_clears: assert property (@(posedge clk) disable iff (rst)
        dir_chg |=> (!flags.full && !flags.intr && !flags.inte));
endmodule

bind hs_port hs_port_chk #(.W(W)) u_hs_port_chk (
    .clk     (clk),
    .rst     (rst),
    .dir_q   (dir_q),
    .dir_chg (dir_chg),
    .cpu_rd  (cpu_rd),
    .cpu_wr  (cpu_wr),
    .hs_rise (hs_rise),
    .flags   (flags),
    .in_lat  (in_lat)
);

// File: tb/hs_port_bench.sv
module hs_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_out = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       bsr_valid = 1'b0;
    logic [2:0] bsr_bit = '0;
    logic       bsr_val = 1'b0;
    logic [7:0] per_data_in = '0;
    logic [7:0] rnd_plain = '0;
    logic       hs_low = 1'b0;
    logic       done = 1'b0;

    logic [7:0] rdata_a, rdata_b, stat_a, stat_b, pout_a, pout_b, dout_a, dout_b;
    logic [7:0] pin_a, pin_b;
    logic       irq_a, irq_b;

    int n_chk = 0;
    int n_fail = 0;

    // model
    logic       m_dir = 1'b0;
    logic       m_full = 1'b0;
    logic [7:0] m_in_lat = '0;
    logic [7:0] m_out_lat = '0;
    logic       m_intr [2];
    logic       m_inte [2];
    logic [7:0] m_plain [2];

    always #10 clk = ~clk;

    function automatic int hs_pos(int i, logic d);
        if (i == 1) return 2;
        return d ? 6 : 4;
    endfunction
    function automatic int bf_pos(int i, logic d);
        if (i == 1) return 1;
        return d ? 7 : 5;
    endfunction
    function automatic int irq_pos(int i);
        return (i == 1) ? 0 : 3;
    endfunction

    assign pin_a = (rnd_plain | 8'h54) & ~(hs_low ? (8'h1 << hs_pos(0, m_dir)) : 8'h0);
    assign pin_b = (rnd_plain | 8'h54) & ~(hs_low ? (8'h1 << hs_pos(1, m_dir)) : 8'h0);

    hs_port u_hs_port (
        .clk(clk), .rst(rst), .dir_out(dir_out), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_a), .bsr_valid(bsr_valid),
        .bsr_bit(bsr_bit), .bsr_val(bsr_val), .pc_status(stat_a),
        .per_data_in(per_data_in), .per_data_out(dout_a), .pc_pin_in(pin_a),
        .pc_pin_out(pout_a), .irq(irq_a)
    );

    hs_port #(.PORT_B(1'b1)) u_hs_port_b (
        .clk(clk), .rst(rst), .dir_out(dir_out), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_b), .bsr_valid(bsr_valid),
        .bsr_bit(bsr_bit), .bsr_val(bsr_val), .pc_status(stat_b),
        .per_data_in(per_data_in), .per_data_out(dout_b), .pc_pin_in(pin_b),
        .pc_pin_out(pout_b), .irq(irq_b)
    );

    function automatic logic bf_exp();
        return m_dir ? ~m_full : m_full;
    endfunction

    function automatic logic [7:0] exp_status(int i);
        logic [7:0] v;
        logic [7:0] pins;
        pins = (i == 1) ? pin_b : pin_a;
        for (int b = 0; b < 8; b++) begin
            if (b == hs_pos(i, m_dir))       v[b] = m_inte[i];
            else if (b == bf_pos(i, m_dir))  v[b] = bf_exp();
            else if (b == irq_pos(i))        v[b] = m_intr[i];
            else                             v[b] = pins[b];
        end
        return v;
    endfunction

    function automatic logic [7:0] exp_pins(int i);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) begin
            if (b == hs_pos(i, m_dir))       v[b] = 1'b0;
            else if (b == bf_pos(i, m_dir))  v[b] = bf_exp();
            else if (b == irq_pos(i))        v[b] = m_intr[i];
            else                             v[b] = m_plain[i][b];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk({tag, "/R10 status"}, (i == 1) ? stat_b : stat_a, exp_status(i));
            chk({tag, "/R9 pins"},    (i == 1) ? pout_b : pout_a, exp_pins(i));
            chk({tag, "/R7 irq"},     {7'b0, (i == 1) ? irq_b : irq_a}, {7'b0, m_intr[i]});
            chk({tag, "/R13 rdata"},  (i == 1) ? rdata_b : rdata_a, m_dir ? m_out_lat : m_in_lat);
            chk({tag, "/R5 dout"},    (i == 1) ? dout_b : dout_a, m_out_lat);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_hs(input logic [7:0] d);
        @(negedge clk);
        per_data_in = d;
        hs_low = 1'b1;
        settle(4);
        hs_low = 1'b0;
        settle(5);
        if (!m_dir) begin
            if (!m_full) begin
                m_in_lat = d;
                m_full = 1'b1;
                for (int i = 0; i < 2; i++) m_intr[i] = m_inte[i];
            end
        end else if (m_full) begin
            m_full = 1'b0;
            for (int i = 0; i < 2; i++) m_intr[i] = m_inte[i];
        end
    endtask

    task automatic cpu_read();
        @(negedge clk);
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        settle(2);
        if (!m_dir) begin
            m_full = 1'b0;
            for (int i = 0; i < 2; i++) m_intr[i] = 1'b0;
        end
    endtask

    task automatic cpu_write(input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        settle(2);
        if (m_dir) begin
            m_out_lat = d;
            m_full = 1'b1;
            for (int i = 0; i < 2; i++) m_intr[i] = 1'b0;
        end
    endtask

    task automatic bsr(input int b, input logic v);
        @(negedge clk);
        bsr_valid = 1'b1;
        bsr_bit = 3'(b);
        bsr_val = v;
        @(negedge clk);
        bsr_valid = 1'b0;
        settle(2);
        for (int i = 0; i < 2; i++) begin
            if (b == hs_pos(i, m_dir)) begin
                m_inte[i] = v;
                if (!v) m_intr[i] = 1'b0;
            end else if (b != bf_pos(i, m_dir) && b != irq_pos(i)) begin
                m_plain[i][b] = v;
            end
        end
    endtask

    task automatic set_dir(input logic v);
        @(negedge clk);
        dir_out = v;
        settle(3);
        if (v != m_dir) begin
            m_dir = v;
            m_full = 1'b0;
            for (int i = 0; i < 2; i++) begin
                m_intr[i] = 1'b0;
                m_inte[i] = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 2; i++) begin
            m_intr[i] = 1'b0;
            m_inte[i] = 1'b0;
            m_plain[i] = '0;
        end
        settle(3);
        rst = 1'b0;
        settle(2);
        check_all("R1 reset");

        // enable interrupts on both slots (A receive: bit 4, B: bit 2)
        bsr(4, 1'b1);
        bsr(2, 1'b1);
        check_all("R11 enable");

        // R2: synchronizer latency on the strobe release
        @(negedge clk);
        per_data_in = 8'hA5;
        hs_low = 1'b1;
        settle(4);
        hs_low = 1'b0;
        settle(2);
        chk("R2 latency two edges", {7'b0, stat_b[1]}, 8'h00);
        settle(1);
        chk("R2 latency three edges", {7'b0, stat_b[1]}, 8'h01);
        settle(3);
        m_in_lat = 8'hA5;
        m_full = 1'b1;
        m_intr[0] = 1'b1;
        m_intr[1] = 1'b1;
        check_all("R2 latch");

        pulse_hs(8'h3C);
        check_all("R3 strobe while full");
        cpu_write(8'h77);
        check_all("R8 write in receive");
        cpu_read();
        check_all("R4 read clears");

        bsr(4, 1'b0);
        bsr(2, 1'b0);
        pulse_hs(8'h5A);
        check_all("R7 disabled no irq");
        bsr(4, 1'b1);
        check_all("R7 late enable no irq");
        cpu_read();

        bsr(5, 1'b1);
        bsr(1, 1'b1);
        check_all("R11 owned ignored");
        bsr(7, 1'b1);
        check_all("R11 plain bit");

        set_dir(1'b1);
        check_all("R12 dir change");
        bsr(6, 1'b1);
        bsr(2, 1'b1);
        cpu_write(8'hC3);
        check_all("R5 write");
        pulse_hs(8'h00);
        check_all("R6 ack");
        pulse_hs(8'h00);
        check_all("R6 ack while empty");
        cpu_read();
        check_all("R8 read in send");
        cpu_write(8'h18);
        check_all("R5 write clears irq");

        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            rnd_plain = 8'($urandom);
            per_data_in = 8'($urandom);
            case (op)
                0, 1, 2: begin pulse_hs(8'($urandom)); check_all("R2 R6 rnd pulse"); end
                3, 4:    begin cpu_read(); check_all("R4 rnd read"); end
                5, 6:    begin cpu_write(8'($urandom)); check_all("R5 rnd write"); end
                7, 8:    begin bsr($urandom_range(0, 7), 1'($urandom)); check_all("R11 rnd bsr"); end
                default: begin set_dir(1'($urandom)); check_all("R12 rnd dir"); end
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule